// File: doc/BRIEF.md
# Converter Configure-and-Acquire Sequencer

This block is a host-side controller for a serial delta-sigma converter. After a start pulse it runs a fixed script over a four-wire SPI link in mode 3. The link has SCLK idling high, data moving MSB first, and chip select pulled low around every single byte.

The script has two parts. First it sends four configuration bytes. The first pair selects the clock register and sets the master-clock divide-by-two and a 50 Hz output rate. The second pair selects the setup register and writes gain 1, bipolar coding, buffer off and filter sync cleared, which starts a self-calibration.

It then enters an acquisition loop. It waits until the converter's active-low data-ready line, after synchronisation, reads low. It sends the read command for the 16-bit data register and clocks in the result as two byte frames. It then presents the word on a one-cycle valid/data port. After the programmed number of samples it pulses done and returns to idle. A later start runs the whole script again from the first configuration byte.

Top module: `adc_sample_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it falls, cs_n_o and sclk_o are 1, and smp_valid_o and done_o are 0.
- R2: After start_i is seen in idle, the first four SPI frames carry, in order, 0x20, 0x0C, 0x10 and 0x40, each in its own cs_n_o low period.
- R3: Every frame has exactly 8 SCLK rising edges, and SCLK is high while cs_n_o is high and when cs_n_o falls. MOSI changes only while SCLK is low, and each frame is sent MSB first.
- R4: Once configuration is done, no read command is issued until the data-ready input, synchronised through two flip-flops, reads low. While drdy_n_i stays high no new frame starts.
- R5: Each sample is one frame carrying 0x38, followed by two read frames. The first read frame gives bits 15:8 and the second gives bits 7:0, each MSB first. Bits are sampled on the rising SCLK edge. The 16-bit word appears on smp_data_o with smp_valid_o high for one cycle.
- R6: During the two read frames the sequencer drives MOSI so that the frame byte is 0x00.
- R7: Exactly NUM_SAMPLES samples are emitted per run. done_o then pulses high for one cycle, never in the same cycle as smp_valid_o, and no further frame starts until the next start.
- R8: start_i has no effect while a run is in progress. A start after done replays the whole script from the first configuration byte.
- R9: Each low half-period of SCLK lasts exactly CLK_DIV system clock cycles. This keeps SCLK at or below the 3 MHz limit for a suitable CLK_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (honoured only in idle) |
| done_o | output | 1 | One-cycle pulse after the last sample |
| sclk_o | output | 1 | SPI serial clock, idles high |
| cs_n_o | output | 1 | Active-low chip select, low around each byte |
| mosi_o | output | 1 | Serial data to converter |
| miso_i | input | 1 | Serial data from converter |
| drdy_n_i | input | 1 | Active-low data-ready from converter (asynchronous) |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| smp_data_o | output | 16 | Sample word, MSB from first read byte |

## Verification
The embedded assertions check the following on every cycle:
- SCLK sits high whenever chip select is released.
- MOSI holds still across each SCLK high phase.
- SCLK half-periods are never shorter than two system cycles.
- A read command is only launched after data-ready was seen low.
- done is a single-cycle pulse that never coincides with a sample strobe.
- The sample counter stays below its limit.

Only the bench's scenarios can show the rest:
- the byte order of the script and the restart from the first byte on a second start;
- the assembled 16-bit values, including all-zero, all-one and single-bit patterns;
- the exact sample count per run;
- that a start mid-run and a long data-ready high period leave the frame stream untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam logic [7:0] CMD_READ = 8'h38;
    localparam logic [7:0] RD_FILL  = 8'h00;
    localparam int         INIT_LEN = 4;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_INIT, SQ_WAIT, SQ_CMD, SQ_RDH, SQ_RDL, SQ_FIN
    } seq_state_e;

    typedef enum logic [2:0] {
        EN_IDLE, EN_LEAD, EN_LOW, EN_HIGH, EN_GAP
    } eng_state_e;

    typedef struct packed {
        logic       go;
        logic [7:0] dat;
    } xfer_req_t;

    typedef struct packed {
        logic       done;
        logic [7:0] dat;
    } xfer_rsp_t;

    // Configuration script: clock-register select, clock setting,
    // setup-register select, setup with self-calibration.
    function automatic logic [7:0] init_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h20;
            2'd1:    return 8'h0C;
            2'd2:    return 8'h10;
            default: return 8'h40;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_fast
            assign tick = !clr;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || clr)       cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
            assign tick = !clr && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/adc_seq_sync2.sv
module adc_seq_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic meta;
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b1;
            q    <= 1'b1;
        end else begin
            meta <= d_async;
            q    <= meta;
        end
    end
endmodule

// File: rtl/adc_seq_spi_byte.sv
module adc_seq_spi_byte
    import adc_seq_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  xfer_req_t req,
    output xfer_rsp_t rsp,
    output logic      sclk_o,
    output logic      cs_n_o,
    output logic      mosi_o,
    input  logic      miso_i
);
    localparam int BW = $clog2(9);
    localparam logic [BW-1:0] NBITS = BW'(8);

    eng_state_e    st;
    logic          tick;
    logic [7:0]    tx, rx;
    logic [BW-1:0] bits;

    adc_seq_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst(rst), .clr(st == EN_IDLE), .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= EN_IDLE;
            sclk_o   <= 1'b1;
            cs_n_o   <= 1'b1;
            mosi_o   <= 1'b0;
            tx       <= '0;
            rx       <= '0;
            bits     <= '0;
            rsp.done <= 1'b0;
            rsp.dat  <= '0;
        end else begin
            rsp.done <= 1'b0;
            case (st)
                EN_IDLE: if (req.go) begin
                    cs_n_o <= 1'b0;
                    tx     <= req.dat;
                    bits   <= '0;
                    st     <= EN_LEAD;
                end
                EN_LEAD, EN_HIGH: if (tick) begin
                    if (st == EN_HIGH && bits == NBITS) begin
                        cs_n_o <= 1'b1;
                        st     <= EN_GAP;
                    end else begin
                        sclk_o <= 1'b0;
                        mosi_o <= tx[7];
                        tx     <= {tx[6:0], 1'b0};
                        st     <= EN_LOW;
                    end
                end
                EN_LOW: if (tick) begin
                    sclk_o <= 1'b1;
                    rx     <= {rx[6:0], miso_i};
                    bits   <= bits + 1'b1;
                    st     <= EN_HIGH;
                end
                EN_GAP: if (tick) begin
                    rsp.done <= 1'b1;
                    rsp.dat  <= rx;
                    st       <= EN_IDLE;
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    AST_CS_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> sclk_o);                                          // R3
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));              // R3

    generate
        if (DIV >= 2) begin : g_half_chk
            AST_HALF_MIN: assert property (@(posedge clk) disable iff (rst)
                (sclk_o != $past(sclk_o)) |=> $stable(sclk_o));      // R9
        end
    endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_SAMPLES = 1000,
    parameter int SMP_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rdy_n_s,
    input  xfer_rsp_t        rsp,
    output xfer_req_t        req,
    output logic             done_o,
    output logic             smp_valid_o,
    output logic [SMP_W-1:0] smp_data_o
);
    localparam int CW = (NUM_SAMPLES > 1) ? $clog2(NUM_SAMPLES) : 1;
    localparam logic [CW-1:0] LAST_SMP = CW'(NUM_SAMPLES - 1);

    seq_state_e st;
    logic [1:0]    idx;
    logic [CW-1:0] cnt;
    logic [7:0]    hi_byte;
    logic          pending;
    logic          need_xfer;

    assign need_xfer = (st == SQ_INIT) || (st == SQ_CMD) ||
                       (st == SQ_RDH)  || (st == SQ_RDL);
    assign req.go  = need_xfer && !pending;
    assign req.dat = (st == SQ_INIT) ? init_byte(idx) :
                     (st == SQ_CMD)  ? CMD_READ : RD_FILL;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= SQ_IDLE;
            idx         <= '0;
            cnt         <= '0;
            hi_byte     <= '0;
            pending     <= 1'b0;
            done_o      <= 1'b0;
            smp_valid_o <= 1'b0;
            smp_data_o  <= '0;
        end else begin
            done_o      <= 1'b0;
            smp_valid_o <= 1'b0;
            if (req.go)        pending <= 1'b1;
            else if (rsp.done) pending <= 1'b0;
            case (st)
                SQ_IDLE: if (start_i) begin
                    idx <= '0;
                    cnt <= '0;
                    st  <= SQ_INIT;
                end
                SQ_INIT: if (rsp.done) begin
                    if (idx == 2'(INIT_LEN - 1)) st <= SQ_WAIT;
                    else                         idx <= idx + 1'b1;
                end
                SQ_WAIT: if (!rdy_n_s) st <= SQ_CMD;
                SQ_CMD:  if (rsp.done) st <= SQ_RDH;
                SQ_RDH:  if (rsp.done) begin
                    hi_byte <= rsp.dat;
                    st      <= SQ_RDL;
                end
                SQ_RDL:  if (rsp.done) begin
                    smp_data_o  <= SMP_W'({hi_byte, rsp.dat});
                    smp_valid_o <= 1'b1;
                    if (cnt == LAST_SMP) st <= SQ_FIN;
                    else begin
                        cnt <= cnt + 1'b1;
                        st  <= SQ_WAIT;
                    end
                end
                SQ_FIN: begin
                    done_o <= 1'b1;
                    st     <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    AST_READ_AFTER_RDY: assert property (@(posedge clk) disable iff (rst)
        (req.go && st == SQ_CMD) |-> !$past(rdy_n_s));               // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                          // R7
    AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
        !(done_o && smp_valid_o));                                    // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_SMP);                                             // R7
endmodule

// File: rtl/adc_sample_sequencer.sv
module adc_sample_sequencer
    import adc_seq_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int NUM_SAMPLES = 1000,
    parameter int SMP_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             done_o,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             mosi_o,
    input  logic             miso_i,
    input  logic             drdy_n_i,
    output logic             smp_valid_o,
    output logic [SMP_W-1:0] smp_data_o
);
    xfer_req_t req;
    xfer_rsp_t rsp;
    logic      rdy_n_s;

    adc_seq_sync2 u_sync (
        .clk(clk), .rst(rst), .d_async(drdy_n_i), .q(rdy_n_s)
    );

    adc_seq_spi_byte #(.DIV(CLK_DIV)) u_spi (
        .clk(clk), .rst(rst), .req(req), .rsp(rsp),
        .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    adc_seq_ctrl #(.NUM_SAMPLES(NUM_SAMPLES), .SMP_W(SMP_W)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .rdy_n_s(rdy_n_s),
        .rsp(rsp), .req(req), .done_o(done_o),
        .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o)
    );
endmodule

// File: tb/tb_adc_sample_sequencer.sv
module tb_adc_sample_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int NS         = 6;
    localparam logic [15:0] VEC [NS] = '{16'h0000, 16'hFFFF, 16'h8000,
                                        16'h0001, 16'hA55A, 16'h7FFF};
    localparam logic [7:0] INIT [4] = '{8'h20, 8'h0C, 8'h10, 8'h40};

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, miso = 1'b0;
    logic done, sclk, cs_n, mosi, valid;
    logic [15:0] data;
    logic drdy_n;

    int checks = 0, fails = 0, finished = 0;
    int req_cnt = 0, vi = 0, nb = 0, bitc = 0, rdph = 0, armed = 0;
    int frame_err = 0, mosi_err = 0, csfall_err = 0, half_err = 0, lowrun = 0;
    int ncap = 0, ndone = 0;
    logic [7:0]  log_b [64];
    logic [15:0] cap [16];
    logic [7:0]  srx = 8'h00, stx = 8'h00;
    logic [15:0] cur = 16'h0000;
    logic prev_sclk = 1'b1, prev_mosi = 1'b0, prev_cs = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign drdy_n = (req_cnt == vi);

    adc_sample_sequencer #(.CLK_DIV(DIV), .NUM_SAMPLES(NS), .SMP_W(16)) dut (
        .clk(clk), .rst(rst), .start_i(start), .done_o(done),
        .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso),
        .drdy_n_i(drdy_n), .smp_valid_o(valid), .smp_data_o(data)
    );

    // Converter model: mode 3 slave
    always @(negedge cs_n) if (armed != 0) begin
        bitc = 0;
        if (rdph == 1)      stx = cur[15:8];
        else if (rdph == 2) stx = cur[7:0];
        else                stx = 8'h00;
    end
    always @(negedge sclk) if (armed != 0 && cs_n == 1'b0) begin
        miso <= stx[7];
        stx = {stx[6:0], 1'b0};
    end
    always @(posedge sclk) if (armed != 0 && cs_n == 1'b0) begin
        srx = {srx[6:0], mosi};
        bitc++;
    end
    always @(posedge cs_n) if (armed != 0) begin
        if (bitc != 8) frame_err++;
        if (nb < 64) log_b[nb] = srx;
        nb++;
        if (rdph == 2) begin
            rdph = 0;
            vi++;
        end else if (rdph == 1) rdph = 2;
        else if (srx == 8'h38) begin
            rdph = 1;
            cur = VEC[vi % NS];
        end
    end

    // Output monitors, sampled away from the active edge
    always @(negedge clk) if (armed != 0) begin
        if (valid && ncap < 16) begin cap[ncap] = data; ncap++; end
        else if (valid) ncap++;
        if (done) ndone++;
        if (sclk && prev_sclk && mosi != prev_mosi) mosi_err++;
        if (!cs_n && prev_cs && !sclk) csfall_err++;
        if (cs_n && !sclk) csfall_err++;
        if (!sclk) lowrun++;
        else if (lowrun > 0) begin
            if (lowrun != DIV) half_err++;
            lowrun = 0;
        end
        prev_sclk = sclk; prev_mosi = mosi; prev_cs = cs_n;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic run_samples(input int base_cap);
        for (int i = 0; i < NS; i++) begin
            int nb0;
            for (int k = 0; k < 4000 && !(nb >= 4 && dut.cs_n_o && drdy_n); k++) @(posedge clk);
            repeat (40) @(posedge clk);
            nb0 = nb;
            repeat (30) @(posedge clk);
            check(nb == nb0, "R4 no frame while data-ready high", nb, nb0);
            req_cnt++;
            for (int k = 0; k < 4000 && ncap < base_cap + i + 1; k++) @(posedge clk);
            @(negedge clk);
            check(ncap == base_cap + i + 1 && cap[base_cap + i] == VEC[i],
                  "R5 sample word", int'(cap[base_cap + i]), int'(VEC[i]));
            if (i == 2) begin
                @(posedge clk) start <= 1'b1;   // R8: ignored mid-run
                @(posedge clk) start <= 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b1, "R1 reset SPI idle", {cs_n, sclk}, 3);
        check(valid == 1'b0 && done == 1'b0, "R1 reset outputs", {valid, done}, 0);
        @(posedge clk) rst <= 1'b0;
        @(negedge clk);
        armed = 1;
        check(cs_n == 1'b1 && sclk == 1'b1, "R1 after reset SPI idle", {cs_n, sclk}, 3);
        check(valid == 1'b0 && done == 1'b0, "R1 after reset outputs", {valid, done}, 0);

        @(posedge clk) start <= 1'b1;
        @(posedge clk) start <= 1'b0;
        run_samples(0);
        for (int k = 0; k < 200 && ndone == 0; k++) @(posedge clk);
        repeat (100) @(posedge clk);
        @(negedge clk);
        for (int j = 0; j < 4; j++)
            check(log_b[j] == INIT[j], "R2 init byte order", int'(log_b[j]), int'(INIT[j]));
        check(nb == 4 + 3 * NS, "R8 mid-run start ignored / R7 frames", nb, 4 + 3 * NS);
        for (int i = 0; i < NS; i++) begin
            check(log_b[4 + 3*i] == 8'h38, "R5 read command", int'(log_b[4 + 3*i]), 'h38);
            check(log_b[5 + 3*i] == 8'h00 && log_b[6 + 3*i] == 8'h00,
                  "R6 read frame fill", int'({log_b[5 + 3*i], log_b[6 + 3*i]}), 0);
        end
        check(ncap == NS, "R7 sample count", ncap, NS);
        check(ndone == 1, "R7 single done pulse", ndone, 1);

        // second run restarts from the configuration bytes
        @(posedge clk) start <= 1'b1;
        @(posedge clk) start <= 1'b0;
        run_samples(NS);
        for (int k = 0; k < 200 && ndone < 2; k++) @(posedge clk);
        @(negedge clk);
        for (int j = 0; j < 4; j++)
            check(log_b[22 + j] == INIT[j], "R8 restart init byte",
                  int'(log_b[22 + j]), int'(INIT[j]));
        check(ndone == 2 && ncap == 2 * NS, "R7 second run count", ncap, 2 * NS);

        check(frame_err == 0, "R3 eight clocks per frame", frame_err, 0);
        check(mosi_err == 0, "R3 MOSI stable while SCLK high", mosi_err, 0);
        check(csfall_err == 0, "R3 SCLK high around CS edges", csfall_err, 0);
        check(half_err == 0, "R9 SCLK low half-period", half_err, 0);

        if (finished == 0) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (finished == 0) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule